// File: doc/BRIEF.md
# Two-Phase Serial Configuration Programmer

This block loads a long configuration shift register on an external device over three lines: serial data, a first-phase clock and a second-phase clock. A host reaches it over a small register bus. The bus has read and write strobes, a 16-bit address, 32-bit data, an acknowledge and an unknown-address flag. Each bit is moved by two separate clock pulses that never overlap, not by a single clock edge.

The block has two ways to send data. In automatic mode the host writes a bit count into the control register and queues 32-bit data words. A sequencer then sends exactly that many bits, most significant bit first, in the order the words were written. In manual mode the host drives the data line, both phase clocks and the load strobe directly from bits of the control register, and the sequencer waits.

The device's serial output is sampled once per shifted bit. The block keeps a CRC-16 over the returned bits and stores them in a small readback memory. The host reads the CRC and any stored word over the bus.

Top module: `cfg_shift_prog`

## Requirements
- R1: An access to an address from 0x0080 to 0x0085 raises `bus_ack_o` for one cycle, on the cycle after the access. An access to any other address raises `bus_unk_o` instead. The two flags are never high together.
- R2: Address 0x0083 is the control register. A read returns the last written value with bits 15:5 forced to zero. Bits 31:16 are the bit count, and writing them reloads the number of bits that remain to be sent.
- R3: Words written to 0x0080 are queued and sent MSB first, in write order. Sending stops once the count is used up, and the unsent bits of that word are dropped. A count that is not a multiple of 32 takes its last bits from the upper part of the final word.
- R4: Each bit takes four quarters of QTR = max(1, (CLK_HZ/SER_HZ)/4) cycles each: data set with both clocks low, then first phase high, then a gap, then second phase high. With the default parameters a bit lasts 8 cycles, and words follow each other without a gap.
- R5: `ph1_o` and `ph2_o` are never high at the same time. In manual mode, asking for both phases at once holds both low.
- R6: When control bit 4 is set (manual mode), bit 0 drives `sdin_o`, bit 1 drives `ph1_o` and bit 2 drives `ph2_o`. The automatic sequencer sends nothing while manual mode is on, and resumes when it is cleared.
- R7: `load_o` is high only while control bits 4 and 3 are both set. Writing the control register without them releases it.
- R8: `sout_i` is sampled on every falling edge of `ph2_o`, in either mode. The samples feed a CRC-16 with polynomial 0x1021, MSB-first update and start value 0xFFFF, and a read of 0x0084 returns that CRC in bits 15:0.
- R9: The k-th returned bit is stored in readback word k/32 at bit position 31-(k mod 32). A write to 0x0085 sets the word index, and a read of 0x0085 returns the word at that index.
- R10: A control write with bit 5 set puts the CRC back to 0xFFFF. A control write with bit 6 set zeroes the readback memory and its bit pointer. Neither bit is stored.
- R11: After reset all outputs are low, the CRC is 0xFFFF, the queue is empty and the bit count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 16 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with the acknowledge |
| bus_ack_o | output | 1 | Access accepted, one cycle after the strobe |
| bus_unk_o | output | 1 | Access to an unknown address |
| sout_i | input | 1 | Serial output returned by the device |
| sdin_o | output | 1 | Serial data to the device |
| ph1_o | output | 1 | First-phase shift clock |
| ph2_o | output | 1 | Second-phase shift clock |
| load_o | output | 1 | Load strobe to the device |

## Verification
The bench models an 8-stage two-phase register on the device side. It checks an 80-bit run whose last word is only half used, which catches a sequencer that sends the full last word or leaves a gap at a word boundary. A 16-bit count with a full word queued checks that the unused bits are dropped. Queuing data while manual mode is on checks that nothing is sent until the mode is cleared, since a design that ignores the mode would start right away. Asking for both manual phases at once must leave both low. The CRC and the readback words are compared with values the bench derives from its own model, both after a run and after a clear, so a wrong sampling edge, bit order or clear shows up as a mismatch.

// File: rtl/cfg_prog_pkg.sv
package cfg_prog_pkg;
  typedef enum logic {SH_IDLE = 1'b0, SH_RUN = 1'b1} sh_state_e;

  localparam logic [15:0] OFF_DATA = 16'h0080;
  localparam logic [15:0] OFF_CTRL = 16'h0083;
  localparam logic [15:0] OFF_CRC  = 16'h0084;
  localparam logic [15:0] OFF_RB   = 16'h0085;
  localparam logic [15:0] OFF_LAST = 16'h0085;

  localparam int CB_SDI    = 0;
  localparam int CB_PH1    = 1;
  localparam int CB_PH2    = 2;
  localparam int CB_LOAD   = 3;
  localparam int CB_MAN    = 4;
  localparam int CB_CLRCRC = 5;
  localparam int CB_CLRRB  = 6;
  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_001F;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/cfg_word_fifo.sv
module cfg_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= din_i;
        wptr_q <= wptr_q + 1'b1;
      end
      if (do_pop) rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/cfg_two_phase_shifter.sv
module cfg_two_phase_shifter
  import cfg_prog_pkg::*;
#(
  parameter int QTR = 2,
  parameter int CW  = 16,
  parameter int WW  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          empty_i,
  input  logic [WW-1:0] data_i,
  output logic          pop_o,
  output logic          sdi_o,
  output logic          ph1_o,
  output logic          ph2_o
);
  localparam int QW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam int BW = $clog2(WW);
  localparam logic [QW-1:0] QLAST = QW'(QTR - 1);
  localparam logic [BW-1:0] BLAST = BW'(WW - 1);

  sh_state_e     st_q;
  logic [WW-1:0] word_q;
  logic [BW-1:0] bidx_q;
  logic [1:0]    slot_q;
  logic [QW-1:0] qcnt_q;
  logic [CW-1:0] left_q;
  logic run, qend, start, bit_end, more, next_word, stop;

  assign run       = (st_q == SH_RUN) && !hold_i;
  assign qend      = (qcnt_q == QLAST);
  assign start     = (st_q == SH_IDLE) && !hold_i && (left_q != '0) && !empty_i;
  assign bit_end   = run && (slot_q == 2'd3) && qend;
  assign more      = left_q > CW'(1);
  assign next_word = bit_end && more && (bidx_q == BLAST) && !empty_i;
  assign stop      = bit_end && (!more || ((bidx_q == BLAST) && empty_i));
  assign pop_o     = start || next_word;

  assign sdi_o = (st_q == SH_RUN) && word_q[WW-1];
  assign ph1_o = (st_q == SH_RUN) && (slot_q == 2'd1);
  assign ph2_o = (st_q == SH_RUN) && (slot_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      word_q <= '0;
      bidx_q <= '0;
      slot_q <= '0;
      qcnt_q <= '0;
      left_q <= '0;
    end else begin
      if (cnt_we_i)                      left_q <= cnt_i;
      else if (bit_end && left_q != '0)  left_q <= left_q - 1'b1;

      if (start)     st_q <= SH_RUN;
      else if (stop) st_q <= SH_IDLE;

      if (start || next_word) begin
        word_q <= data_i;
        bidx_q <= '0;
      end else if (bit_end) begin
        word_q <= word_q << 1;
        bidx_q <= bidx_q + 1'b1;
      end

      if (start) begin
        slot_q <= '0;
        qcnt_q <= '0;
      end else if (run) begin
        if (qend) begin
          qcnt_q <= '0;
          slot_q <= slot_q + 1'b1;
        end else begin
          qcnt_q <= qcnt_q + 1'b1;
        end
      end
    end
  end

  a_r3_pop_needs_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> left_q != '0);
  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> left_q <= $past(left_q));
  a_r6_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !cnt_we_i) |=> ($stable(slot_q) && $stable(left_q) && $stable(st_q)));
endmodule

// File: rtl/cfg_return_monitor.sv
module cfg_return_monitor
  import cfg_prog_pkg::*;
#(
  parameter int RB_WORDS = 4,
  parameter int IW = $clog2(RB_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_i,
  input  logic          bit_i,
  input  logic          clr_crc_i,
  input  logic          clr_rb_i,
  input  logic [IW-1:0] idx_i,
  output logic [15:0]   crc_o,
  output logic [31:0]   word_o
);
  localparam int CAP = RB_WORDS * 32;
  localparam int PW  = $clog2(CAP + 1);

  logic [31:0]   mem_q [RB_WORDS];
  logic [PW-1:0] ptr_q;
  logic [15:0]   crc_q;
  logic          fb, room;

  assign fb     = crc_q[15] ^ bit_i;
  assign room   = ptr_q < PW'(CAP);
  assign crc_o  = crc_q;
  assign word_o = mem_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= CRC_INIT;
    end else if (clr_crc_i) begin
      crc_q <= CRC_INIT;
    end else if (smp_i) begin
      crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int w = 0; w < RB_WORDS; w++) mem_q[w] <= '0;
    end else if (clr_rb_i) begin
      ptr_q <= '0;
      for (int w = 0; w < RB_WORDS; w++) mem_q[w] <= '0;
    end else if (smp_i && room) begin
      ptr_q <= ptr_q + 1'b1;
      for (int w = 0; w < RB_WORDS; w++)
        if (ptr_q[PW-1:5] == (PW-5)'(w)) mem_q[w][5'd31 - ptr_q[4:0]] <= bit_i;
    end
  end

  a_r10_crc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_crc_i |=> crc_q == CRC_INIT);
  a_r9_ptr_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_rb_i |=> ptr_q >= $past(ptr_q));
  a_r9_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PW'(CAP));
endmodule

// File: rtl/cfg_shift_prog.sv
module cfg_shift_prog
  import cfg_prog_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int SER_HZ     = 10_000_000,
  parameter int FIFO_DEPTH = 4,
  parameter int RB_WORDS   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [15:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        bus_ack_o,
  output logic        bus_unk_o,
  input  logic        sout_i,
  output logic        sdin_o,
  output logic        ph1_o,
  output logic        ph2_o,
  output logic        load_o
);
  localparam int DIV = CLK_HZ / SER_HZ;
  localparam int QTR = (DIV / 4 < 1) ? 1 : DIV / 4;
  localparam int IW  = $clog2(RB_WORDS);

  logic [31:0]   ctrl_q, rdata_q, fifo_dout, rb_word, rd_mux;
  logic [IW-1:0] idx_q;
  logic [15:0]   crc;
  logic          ack_q, unk_q, ph2_d_q;
  logic          acc, hit, ctrl_we, push, pop, empty, full, manual;
  logic          sh_sdi, sh_ph1, sh_ph2, smp;

  assign acc     = bus_wr_i || bus_rd_i;
  assign hit     = (bus_addr_i >= OFF_DATA) && (bus_addr_i <= OFF_LAST);
  assign ctrl_we = bus_wr_i && (bus_addr_i == OFF_CTRL);
  assign push    = bus_wr_i && (bus_addr_i == OFF_DATA);
  assign manual  = ctrl_q[CB_MAN];

  cfg_word_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(bus_wdata_i), .pop_i(pop),
    .dout_o(fifo_dout), .empty_o(empty), .full_o(full)
  );

  cfg_two_phase_shifter #(.QTR(QTR), .CW(16), .WW(32)) u_shifter (
    .clk_i, .rst_ni, .hold_i(manual), .cnt_we_i(ctrl_we), .cnt_i(bus_wdata_i[31:16]),
    .empty_i(empty), .data_i(fifo_dout), .pop_o(pop),
    .sdi_o(sh_sdi), .ph1_o(sh_ph1), .ph2_o(sh_ph2)
  );

  // manual phases are gated against each other
  assign sdin_o = manual ? ctrl_q[CB_SDI] : sh_sdi;
  assign ph1_o  = manual ? (ctrl_q[CB_PH1] && !ctrl_q[CB_PH2]) : sh_ph1;
  assign ph2_o  = manual ? (ctrl_q[CB_PH2] && !ctrl_q[CB_PH1]) : sh_ph2;
  assign load_o = manual && ctrl_q[CB_LOAD];
  assign smp    = ph2_d_q && !ph2_o;

  cfg_return_monitor #(.RB_WORDS(RB_WORDS), .IW(IW)) u_ret (
    .clk_i, .rst_ni, .smp_i(smp), .bit_i(sout_i),
    .clr_crc_i(ctrl_we && bus_wdata_i[CB_CLRCRC]),
    .clr_rb_i(ctrl_we && bus_wdata_i[CB_CLRRB]),
    .idx_i(idx_q), .crc_o(crc), .word_o(rb_word)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFF_CTRL: rd_mux = ctrl_q;
      OFF_CRC:  rd_mux = {16'h0000, crc};
      OFF_RB:   rd_mux = rb_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      idx_q   <= '0;
      ack_q   <= 1'b0;
      unk_q   <= 1'b0;
      rdata_q <= '0;
      ph2_d_q <= 1'b0;
    end else begin
      ph2_d_q <= ph2_o;
      ack_q   <= acc && hit;
      unk_q   <= acc && !hit;
      rdata_q <= (bus_rd_i && hit) ? rd_mux : '0;
      if (ctrl_we) ctrl_q <= bus_wdata_i & CTRL_KEEP;
      if (bus_wr_i && bus_addr_i == OFF_RB) idx_q <= bus_wdata_i[IW-1:0];
    end
  end

  assign bus_ack_o   = ack_q;
  assign bus_unk_o   = unk_q;
  assign bus_rdata_o = rdata_q;

  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph1_o && ph2_o));
  a_r1_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_ack_o && bus_unk_o));
  a_r1_ack_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && hit) |=> bus_ack_o);
  a_r1_unk_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !hit) |=> (bus_unk_o && !bus_ack_o));
  a_r3_push_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full) |=> !empty);
endmodule

// File: tb/cfg_shift_prog_bench.sv
module cfg_shift_prog_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_ack_o, bus_unk_o;
  logic        sout_i = 1'b0;
  logic        sdin_o, ph1_o, ph2_o, load_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  cfg_shift_prog u_cfg_shift_prog (
    .clk_i, .rst_ni, .bus_wr_i, .bus_rd_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .bus_ack_o, .bus_unk_o, .sout_i, .sdin_o, .ph1_o, .ph2_o, .load_o
  );

  // device-side model: ph1 rise latches sdin, ph2 rise shifts an 8-stage chain
  int       cyc = 0;
  logic     sent_bits [512];
  int       n_sent = 0;
  int       n_overlap = 0;
  int       last_rise = -1, per_min = 1000, per_max = 0;
  logic     m_cap = 1'b0, m_ph1_d = 1'b0, m_ph2_d = 1'b0;
  logic [7:0] m_chain = '0;

  always @(posedge clk_i) cyc++;

  always @(negedge clk_i) begin
    if (ph1_o && ph2_o) n_overlap++;
    if (ph1_o && !m_ph1_d) begin
      m_cap = sdin_o;
      if (n_sent < 512) sent_bits[n_sent] = sdin_o;
      n_sent++;
      if (last_rise >= 0 && (cyc - last_rise) < 100) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
    end
    if (ph2_o && !m_ph2_d) begin
      m_chain = {m_chain[6:0], m_cap};
      sout_i  = m_chain[7];
    end
    m_ph1_d = ph1_o;
    m_ph2_d = ph2_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic [15:0] a,
                        input logic [31:0] d, output logic ack, output logic unk,
                        output logic [31:0] q);
    bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_rd_i = 1'b0; bus_wr_i = 1'b0;
    ack = bus_ack_o; unk = bus_unk_o; q = bus_rdata_o;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic k, u; logic [31:0] q;
    access(1'b0, 1'b1, a, d, k, u, q);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] q);
    logic k, u;
    access(1'b1, 1'b0, a, 32'h0, k, u, q);
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  // {rd, wr, addr, wdata, exp_ack, exp_unk, exp_rdata}
  localparam logic [83:0] TBL [8] = '{
    {1'b0, 1'b1, 16'h007F, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000},
    {1'b1, 1'b0, 16'h0086, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000},
    {1'b0, 1'b1, 16'h0083, 32'h0003_0001, 1'b1, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 16'h0083, 32'h0000_0000, 1'b1, 1'b0, 32'h0003_0001},
    {1'b0, 1'b1, 16'h0083, 32'hABCD_00EF, 1'b1, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 16'h0083, 32'h0000_0000, 1'b1, 1'b0, 32'hABCD_000F},
    {1'b1, 1'b0, 16'h0081, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 16'h0084, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_FFFF}
  };

  localparam logic [79:0] TD = 80'hAAAAAAAA_BBBBBBBB_CCCC;

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic        k, u;
    logic [31:0] q, expw;
    logic [15:0] ecrc;
    logic        ret [80];
    int          base, bad;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 outputs after reset", {26'h0, bus_ack_o, bus_unk_o, sdin_o, ph1_o, ph2_o, load_o}, 32'h0);

    // R1 R2 R8 R10 table of bus accesses
    for (int i = 0; i < 8; i++) begin
      access(TBL[i][83], TBL[i][82], TBL[i][81:66], TBL[i][65:34], k, u, q);
      chk($sformatf("R1 ack/unk entry %0d", i), {30'h0, k, u}, {30'h0, TBL[i][33], TBL[i][32]});
      if (TBL[i][83]) chk($sformatf("R2 rdata entry %0d", i), q, TBL[i][31:0]);
    end
    // R7 load bit without manual mode
    chk("R7 load without manual", {31'h0, load_o}, 32'h0);

    // R3 R4 80-bit automatic run, last word half used
    wr(16'h0083, 32'h0000_0060);
    base = n_sent;
    wr(16'h0083, 32'h0050_0000);
    wr(16'h0080, 32'hAAAA_AAAA);
    wr(16'h0080, 32'hBBBB_BBBB);
    wr(16'h0080, 32'hCCCC_0000);
    repeat (800) @(negedge clk_i);
    chk("R3 bits sent", n_sent - base, 80);
    bad = 0;
    for (int j = 0; j < 80; j++) if (sent_bits[base + j] !== TD[79 - j]) bad++;
    chk("R3 bit order", bad, 0);
    chk("R4 bit period min", per_min, 8);
    chk("R4 bit period max", per_max, 8);

    // R8 CRC over returned bits (8-stage chain started empty)
    ecrc = 16'hFFFF;
    for (int j = 0; j < 80; j++) begin
      ret[j] = (j >= 7) ? TD[79 - (j - 7)] : 1'b0;
      ecrc = crc_step(ecrc, ret[j]);
    end
    rd(16'h0084, q);
    chk("R8 crc after run", q, {16'h0, ecrc});

    // R9 readback words
    for (int w = 0; w < 3; w++) begin
      expw = '0;
      for (int j = 0; j < 32; j++) if (32 * w + j < 80) expw[31 - j] = ret[32 * w + j];
      wr(16'h0085, w);
      rd(16'h0085, q);
      chk($sformatf("R9 readback word %0d", w), q, expw);
    end

    // R10 clears
    wr(16'h0083, 32'h0000_0060);
    rd(16'h0084, q);
    chk("R10 crc cleared", q, 32'h0000_FFFF);
    wr(16'h0085, 32'h0);
    rd(16'h0085, q);
    chk("R10 readback cleared", q, 32'h0);
    rd(16'h0083, q);
    chk("R10 clear bits not stored", q, 32'h0);

    // R3 count shorter than the word
    base = n_sent;
    wr(16'h0083, 32'h0010_0000);
    wr(16'h0080, 32'h1234_5678);
    repeat (300) @(negedge clk_i);
    chk("R3 short count bits", n_sent - base, 16);
    bad = 0;
    for (int j = 0; j < 16; j++) if (sent_bits[base + j] !== 1'(32'h1234 >> (15 - j))) bad++;
    chk("R3 short count order", bad, 0);

    // R6 manual mode holds the sequencer
    base = n_sent;
    wr(16'h0083, 32'h0008_0010);
    wr(16'h0080, 32'hF000_0000);
    repeat (100) @(negedge clk_i);
    chk("R6 no shifting in manual", n_sent - base, 0);
    wr(16'h0083, 32'h0008_0000);
    repeat (120) @(negedge clk_i);
    chk("R6 resumes after manual", n_sent - base, 8);
    bad = 0;
    for (int j = 0; j < 8; j++) if (sent_bits[base + j] !== (j < 4)) bad++;
    chk("R6 resumed bit values", bad, 0);

    // R6 R8 manual bit-bang of one bit
    wr(16'h0083, 32'h0000_0060);
    wr(16'h0083, 32'h0000_0011);
    chk("R6 manual data only", {29'h0, sdin_o, ph1_o, ph2_o}, 32'h4);
    wr(16'h0083, 32'h0000_0013);
    chk("R6 manual phase one", {29'h0, sdin_o, ph1_o, ph2_o}, 32'h6);
    wr(16'h0083, 32'h0000_0015);
    chk("R6 manual phase two", {29'h0, sdin_o, ph1_o, ph2_o}, 32'h5);
    wr(16'h0083, 32'h0000_0010);
    repeat (3) @(negedge clk_i);
    ecrc = crc_step(16'hFFFF, sout_i);
    rd(16'h0084, q);
    chk("R8 crc after manual bit", q, {16'h0, ecrc});
    rd(16'h0085, q);
    chk("R9 manual bit stored", q, {sout_i, 31'h0});

    // R5 both phases requested
    wr(16'h0083, 32'h0000_0016);
    chk("R5 both phases held low", {30'h0, ph1_o, ph2_o}, 32'h0);
    chk("R5 overlap count", n_overlap, 0);

    // R7 load strobe
    wr(16'h0083, 32'h0000_0018);
    chk("R7 load asserted", {31'h0, load_o}, 32'h1);
    wr(16'h0083, 32'h0000_0000);
    chk("R7 load released", {31'h0, load_o}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule